// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of a small set of cache lines, one data word per line, in a snooping system where a fixed number of peer caches share a message fabric. Each line is in one of four states: Invalid, Shared (read-only, other copies may exist), Exclusive (the only copy, clean) or Modified (the only copy, dirty). The processor side issues read, write, atomic add, claim (take the only copy without writing), clean (write back but keep ownership) and evict requests. The line index is the address; there are no tags.

On a hit that needs no permission, the controller answers in one cycle and sends nothing. On a miss, or when it needs ownership, it sends a request message. It stalls the processor with `busy` until the data has arrived and every peer has acknowledged. There is no directory, so every peer acknowledges every invalidate. Independently, and in every cycle, it answers snooped Read, Invalidate and Read Invalidate messages from peers. It supplies data when it owns the line and demotes or drops the line.

Message codes on `out_msg` and `in_msg` are: 0 Read, 1 Read Response, 2 Invalidate, 3 Invalidate Acknowledge, 4 Read Invalidate, 5 Writeback. Request codes on `req_op` are: 0 read, 1 write, 2 atomic add, 3 claim, 4 clean, 5 evict. State codes on `done_state` are: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid with a zero data word, and `busy`, `done`, `out_valid`, `snp_rdresp` and `snp_ack` are 0; a first read of any line therefore sends Read (code 0).
- R2: A read of a valid line completes with `done` one cycle after the request, sends no message, and leaves the state unchanged. A read of an Invalid line sends Read and waits for a Read Response (code 1) on that line. It then completes one cycle later in Shared, returning and storing the received word.
- R3: A write or atomic to an Exclusive or Modified line completes one cycle after the request in Modified with no message sent.
- R4: A write or atomic to an Invalid line sends Read Invalidate (code 4) and keeps `busy` high with `done` low until the Read Response and NPEERS Invalidate Acknowledges (code 3) for that line have all arrived, in either order. It completes in Modified one cycle after the last of them.
- R5: A write or atomic to a Shared line sends Invalidate (code 2) and completes in Modified one cycle after the NPEERS-th Invalidate Acknowledge for that line; acknowledges naming another line are not counted.
- R6: An atomic returns the line's previous word on `done_rdata` and stores the previous word plus `req_wdata`; a write returns the previous word and stores `req_wdata`.
- R7: A claim of a Shared line sends Invalidate and completes in Exclusive after all NPEERS acknowledges; a claim of any other state completes at once, unchanged.
- R8: A clean of a Modified line sends Writeback (code 5) carrying the word and leaves the line Exclusive. An evict of a Modified line sends Writeback and leaves it Invalid. An evict of any other state sends nothing and leaves it Invalid; both complete at once.
- R9: A snooped Read on a Modified or Exclusive line produces `snp_rdresp` with the word one cycle later and leaves the line Shared; on Shared or Invalid it produces no response and no change.
- R10: A snooped Invalidate always produces `snp_ack` one cycle later, whatever the line's state, and leaves the line Invalid.
- R11: A snooped Read Invalidate produces `snp_ack` one cycle later and leaves the line Invalid; it also produces `snp_rdresp` with the word if the line was Modified or Exclusive.
- R12: While `busy` is high, new processor requests are ignored: no message is sent for them and the targeted line keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present (taken when `busy` is low) |
| req_op | input | 3 | Request code |
| req_line | input | IW | Target line index |
| req_wdata | input | DW | Write data or atomic addend |
| busy | output | 1 | A request is waiting for messages |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Line word before the request |
| done_state | output | 2 | Line state after the request |
| out_valid | output | 1 | Outgoing request message valid |
| out_msg | output | 3 | Outgoing message code |
| out_line | output | IW | Outgoing message line |
| out_data | output | DW | Writeback data |
| in_valid | input | 1 | Incoming message valid |
| in_msg | input | 3 | Incoming message code |
| in_line | input | IW | Incoming message line |
| in_data | input | DW | Incoming Read Response data |
| snp_rdresp | output | 1 | Read Response sent to a snooper |
| snp_ack | output | 1 | Invalidate Acknowledge sent to a snooper |
| snp_line | output | IW | Line of the snoop reply |
| snp_data | output | DW | Data of the snoop Read Response |

## Verification
A wrong stored state shows up at the ports on the next touch of that line. A line that is wrongly valid completes a read one cycle after the request with no Read message. A line that is wrongly Invalid sends a message where a silent hit was due. Any wrong state also appears directly on `done_state` one cycle after a request. For snoops, a wrong state shows as a missing or extra `snp_rdresp` one cycle after the snooped message. A miscounted acknowledge shows as `done` rising one acknowledge early, or `busy` never falling, so the bench checks `busy` and `done` after every peer message.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    M_READ   = 3'd0,
    M_RDRESP = 3'd1,
    M_INV    = 3'd2,
    M_INVACK = 3'd3,
    M_RDINV  = 3'd4,
    M_WB     = 3'd5
  } msg_t;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ATOMIC = 3'd2,
    OP_CLAIM  = 3'd3,
    OP_CLEAN  = 3'd4,
    OP_EVICT  = 3'd5
  } op_t;
endpackage

// File: rtl/coh_line_store.sv
// Per-line state and data word. Processor port and snoop port read in
// parallel; a processor write wins over a snoop write to the same line.
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DW     = 16,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   p_idx,
  output line_st_t        p_state,
  output logic [DW-1:0]   p_data,
  input  logic [IW-1:0]   s_idx,
  output line_st_t        s_state,
  output logic [DW-1:0]   s_data,
  input  logic            pw_en,
  input  line_st_t        pw_state,
  input  logic [DW-1:0]   pw_data,
  input  logic            sw_en,
  input  line_st_t        sw_state
);
  line_st_t      st_arr  [NLINES];
  logic [DW-1:0] dat_arr [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_st_t      st_r;
    logic [DW-1:0] d_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_r <= ST_I;
        d_r  <= '0;
      end else if (pw_en && p_idx == IW'(g)) begin
        st_r <= pw_state;
        d_r  <= pw_data;
      end else if (sw_en && s_idx == IW'(g)) begin
        st_r <= sw_state;
      end
    end
    assign st_arr[g]  = st_r;
    assign dat_arr[g] = d_r;
  end

  assign p_state = st_arr[p_idx];
  assign p_data  = dat_arr[p_idx];
  assign s_state = st_arr[s_idx];
  assign s_data  = dat_arr[s_idx];
endmodule

// File: rtl/coh_ack_counter.sv
// Down-counter of outstanding invalidate acknowledges.
module coh_ack_counter #(
  parameter int NPEERS = 3,
  localparam int CW    = $clog2(NPEERS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_peers,
  input  logic dec,
  output logic zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_peers ? CW'(NPEERS) : '0;
    else if (dec && cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/coh_snoop_unit.sv
// Decides the reply and the new line state for a snooped message.
module coh_snoop_unit
  import coh_pkg::*;
(
  input  logic       in_valid,
  input  logic [2:0] in_msg,
  input  line_st_t   cur,
  output logic       upd,
  output line_st_t   nxt,
  output logic       give_data,
  output logic       give_ack
);
  logic owner;
  assign owner = (cur == ST_M) || (cur == ST_E);

  always_comb begin
    upd       = 1'b0;
    nxt       = cur;
    give_data = 1'b0;
    give_ack  = 1'b0;
    if (in_valid) begin
      case (msg_t'(in_msg))
        M_READ: begin
          if (owner) begin
            upd       = 1'b1;
            nxt       = ST_S;
            give_data = 1'b1;
          end
        end
        M_INV: begin
          upd      = 1'b1;
          nxt      = ST_I;
          give_ack = 1'b1;
        end
        M_RDINV: begin
          upd       = 1'b1;
          nxt       = ST_I;
          give_ack  = 1'b1;
          give_data = owner;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DW     = 16,
  parameter int NPEERS = 3,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [IW-1:0] req_line,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic [1:0]    done_state,
  output logic          out_valid,
  output logic [2:0]    out_msg,
  output logic [IW-1:0] out_line,
  output logic [DW-1:0] out_data,
  input  logic          in_valid,
  input  logic [2:0]    in_msg,
  input  logic [IW-1:0] in_line,
  input  logic [DW-1:0] in_data,
  output logic          snp_rdresp,
  output logic          snp_ack,
  output logic [IW-1:0] snp_line,
  output logic [DW-1:0] snp_data
);
  // pending request
  logic          busy_q;
  op_t           pend_op;
  logic [IW-1:0] pend_line;
  logic [DW-1:0] pend_wdata;
  logic          pend_need_data;
  logic          pend_have_data;
  logic [DW-1:0] pend_data;

  // store ports
  logic [IW-1:0] p_idx;
  line_st_t      p_state, s_state;
  logic [DW-1:0] p_data, s_data;
  logic          pw_en;
  line_st_t      pw_state;
  logic [DW-1:0] pw_data;
  logic          sw_en;
  line_st_t      sw_state;

  // snoop decode
  logic sn_data, sn_ack;

  // control
  logic          accept, complete, local_done, issue, wb, need_data, need_acks;
  logic          capture, ack_dec, ack_zero;
  msg_t          issue_msg;
  logic [DW-1:0] base, fin_rdata;

  assign accept   = req_valid && !busy_q;
  assign p_idx    = busy_q ? pend_line : req_line;
  assign complete = busy_q && (!pend_need_data || pend_have_data) && ack_zero;
  assign base     = pend_have_data ? pend_data : p_data;
  assign capture  = busy_q && pend_need_data && !pend_have_data && in_valid &&
                    (in_msg == M_RDRESP) && (in_line == pend_line);
  assign ack_dec  = busy_q && in_valid && (in_msg == M_INVACK) && (in_line == pend_line);

  coh_line_store #(.NLINES(NLINES), .DW(DW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .p_idx    (p_idx),
    .p_state  (p_state),
    .p_data   (p_data),
    .s_idx    (in_line),
    .s_state  (s_state),
    .s_data   (s_data),
    .pw_en    (pw_en),
    .pw_state (pw_state),
    .pw_data  (pw_data),
    .sw_en    (sw_en),
    .sw_state (sw_state)
  );

  coh_ack_counter #(.NPEERS(NPEERS)) u_acks (
    .clk        (clk),
    .rst        (rst),
    .load       (issue),
    .load_peers (need_acks),
    .dec        (ack_dec),
    .zero       (ack_zero)
  );

  coh_snoop_unit u_snoop (
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .cur       (s_state),
    .upd       (sw_en),
    .nxt       (sw_state),
    .give_data (sn_data),
    .give_ack  (sn_ack)
  );

  always_comb begin
    issue      = 1'b0;
    issue_msg  = M_READ;
    need_data  = 1'b0;
    need_acks  = 1'b0;
    local_done = 1'b0;
    wb         = 1'b0;
    pw_en      = 1'b0;
    pw_state   = p_state;
    pw_data    = p_data;
    fin_rdata  = p_data;
    if (complete) begin
      pw_en     = 1'b1;
      fin_rdata = base;
      case (pend_op)
        OP_READ:   begin pw_state = ST_S; pw_data = base;              end
        OP_WRITE:  begin pw_state = ST_M; pw_data = pend_wdata;        end
        OP_ATOMIC: begin pw_state = ST_M; pw_data = base + pend_wdata; end
        default:   begin pw_state = ST_E;                              end
      endcase
    end else if (accept) begin
      case (op_t'(req_op))
        OP_READ: begin
          if (p_state == ST_I) begin
            issue = 1'b1; issue_msg = M_READ; need_data = 1'b1;
          end else begin
            local_done = 1'b1;
          end
        end
        OP_WRITE, OP_ATOMIC: begin
          if (p_state == ST_M || p_state == ST_E) begin
            local_done = 1'b1;
            pw_en      = 1'b1;
            pw_state   = ST_M;
            pw_data    = (op_t'(req_op) == OP_WRITE) ? req_wdata : p_data + req_wdata;
          end else if (p_state == ST_S) begin
            issue = 1'b1; issue_msg = M_INV; need_acks = 1'b1;
          end else begin
            issue = 1'b1; issue_msg = M_RDINV; need_data = 1'b1; need_acks = 1'b1;
          end
        end
        OP_CLAIM: begin
          if (p_state == ST_S) begin
            issue = 1'b1; issue_msg = M_INV; need_acks = 1'b1;
          end else begin
            local_done = 1'b1;
          end
        end
        OP_CLEAN: begin
          local_done = 1'b1;
          if (p_state == ST_M) begin
            wb = 1'b1; pw_en = 1'b1; pw_state = ST_E;
          end
        end
        OP_EVICT: begin
          local_done = 1'b1;
          pw_en      = 1'b1;
          pw_state   = ST_I;
          wb         = (p_state == ST_M);
        end
        default: local_done = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q         <= 1'b0;
      pend_op        <= OP_READ;
      pend_line      <= '0;
      pend_wdata     <= '0;
      pend_need_data <= 1'b0;
      pend_have_data <= 1'b0;
      pend_data      <= '0;
      done           <= 1'b0;
      done_rdata     <= '0;
      done_state     <= 2'd0;
      out_valid      <= 1'b0;
      out_msg        <= 3'd0;
      out_line       <= '0;
      out_data       <= '0;
      snp_rdresp     <= 1'b0;
      snp_ack        <= 1'b0;
      snp_line       <= '0;
      snp_data       <= '0;
    end else begin
      done       <= complete || local_done;
      done_rdata <= fin_rdata;
      done_state <= pw_state;
      out_valid  <= issue || wb;
      out_msg    <= issue ? issue_msg : M_WB;
      out_line   <= p_idx;
      out_data   <= p_data;
      snp_rdresp <= sn_data;
      snp_ack    <= sn_ack;
      snp_line   <= in_line;
      snp_data   <= s_data;
      if (complete)
        busy_q <= 1'b0;
      else if (issue)
        busy_q <= 1'b1;
      if (issue) begin
        pend_op        <= op_t'(req_op);
        pend_line      <= req_line;
        pend_wdata     <= req_wdata;
        pend_need_data <= need_data;
        pend_have_data <= 1'b0;
      end else if (capture) begin
        pend_have_data <= 1'b1;
        pend_data      <= in_data;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       out_valid,
  input logic [2:0] out_msg,
  input logic       in_valid,
  input logic [2:0] in_msg,
  input logic       snp_rdresp,
  input logic       snp_ack
);
  // R12
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12
  no_issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$past(busy));

  // R4
  rdinv_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_msg == 3'd4) |-> busy);

  // R5
  inval_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_msg == 3'd2) |-> busy);

  // R8
  wb_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_msg == 3'd5) |-> (done && !busy));

  // R10
  inval_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_msg == 3'd2) |=> snp_ack);

  // R11
  rdinv_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_msg == 3'd4) |=> snp_ack);

  // R9
  rdresp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snp_rdresp |-> ($past(in_valid) && ($past(in_msg) == 3'd0 || $past(in_msg) == 3'd4)));
endmodule

bind coh_line_ctrl coh_line_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .out_valid  (out_valid),
  .out_msg    (out_msg),
  .in_valid   (in_valid),
  .in_msg     (in_msg),
  .snp_rdresp (snp_rdresp),
  .snp_ack    (snp_ack)
);

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [2:0]    req_line = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done;
  logic [DW-1:0] done_rdata;
  logic [1:0]    done_state;
  logic          out_valid;
  logic [2:0]    out_msg;
  logic [2:0]    out_line;
  logic [DW-1:0] out_data;
  logic          in_valid = 1'b0;
  logic [2:0]    in_msg = '0;
  logic [2:0]    in_line = '0;
  logic [DW-1:0] in_data = '0;
  logic          snp_rdresp, snp_ack;
  logic [2:0]    snp_line;
  logic [DW-1:0] snp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int            m_st  [NL];
  logic [DW-1:0] m_dat [NL];

  always #10 clk = ~clk;

  coh_line_ctrl #(.NLINES(NL), .DW(DW), .NPEERS(NP)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_line(req_line), .req_wdata(req_wdata),
    .busy(busy), .done(done), .done_rdata(done_rdata), .done_state(done_state),
    .out_valid(out_valid), .out_msg(out_msg), .out_line(out_line), .out_data(out_data),
    .in_valid(in_valid), .in_msg(in_msg), .in_line(in_line), .in_data(in_data),
    .snp_rdresp(snp_rdresp), .snp_ack(snp_ack), .snp_line(snp_line), .snp_data(snp_data)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one peer/memory message, then the request must still be pending
  task automatic send(input int msg, input int ln, input logic [DW-1:0] d, input string tag);
    in_valid = 1'b1; in_msg = 3'(msg); in_line = 3'(ln); in_data = d;
    tick();
    in_valid = 1'b0;
    chk(tag, "busy while waiting", busy, 1);
    chk(tag, "done while waiting", done, 0);
  endtask

  task automatic proc(input int op, input int ln, input logic [DW-1:0] wd,
                      input bit ackfirst, input bit stray);
    int s, emsg, fs;
    bit nd, na;
    logic [DW-1:0] old, rv, fd, er, b;
    string tag, dtag;
    s = m_st[ln]; old = m_dat[ln]; rv = DW'($urandom);
    emsg = -1; nd = 0; na = 0; fs = s; fd = old; er = old; b = old; tag = "R2";
    case (op)
      0: begin
        tag = "R2";
        if (s == 0) begin emsg = 0; nd = 1; fs = 1; fd = rv; er = rv; end
      end
      1, 2: begin
        if (s >= 2) tag = "R3";
        else if (s == 1) begin tag = "R5"; emsg = 2; na = 1; end
        else begin tag = "R4"; emsg = 4; nd = 1; na = 1; b = rv; end
        fs = 3; er = b; fd = (op == 1) ? wd : b + wd;
      end
      3: begin
        tag = "R7";
        if (s == 1) begin emsg = 2; na = 1; fs = 2; end
      end
      4: begin
        tag = "R8";
        if (s == 3) begin emsg = 5; fs = 2; end
      end
      default: begin
        tag = "R8";
        if (s == 3) emsg = 5;
        fs = 0;
      end
    endcase
    dtag = (op == 2) ? "R6" : tag;
    req_valid = 1'b1; req_op = 3'(op); req_line = 3'(ln); req_wdata = wd;
    tick();
    req_valid = 1'b0;
    chk(tag, "out_valid", out_valid, (emsg >= 0) ? 1 : 0);
    if (emsg >= 0) begin
      chk(tag, "out_msg", out_msg, emsg);
      chk(tag, "out_line", out_line, ln);
    end
    if (emsg == 5) chk(tag, "writeback data", out_data, old);
    if (emsg < 0 || emsg == 5) begin
      chk(tag, "immediate done", done, 1);
    end else begin
      chk(tag, "busy after issue", busy, 1);
      chk(tag, "no done at issue", done, 0);
      if (stray && na) send(3, ln ^ 1, '0, tag);
      if (nd && !ackfirst) send(1, ln, rv, tag);
      if (na) for (int k = 0; k < NP; k++) send(3, ln, '0, tag);
      if (nd && ackfirst) send(1, ln, rv, tag);
      tick();
      chk(tag, "done after last message", done, 1);
      chk(tag, "busy released", busy, 0);
    end
    chk(tag, "done_state", done_state, fs);
    chk(dtag, "done_rdata", done_rdata, er);
    m_st[ln] = fs; m_dat[ln] = fd;
  endtask

  task automatic snoop(input int msg, input int ln);
    int s, nx;
    bit gd, ga;
    string tag;
    s = m_st[ln]; nx = s; gd = 0; ga = 0;
    case (msg)
      0: begin tag = "R9"; if (s >= 2) begin gd = 1; nx = 1; end end
      2: begin tag = "R10"; ga = 1; nx = 0; end
      default: begin tag = "R11"; ga = 1; nx = 0; gd = (s >= 2); end
    endcase
    in_valid = 1'b1; in_msg = 3'(msg); in_line = 3'(ln); in_data = '0;
    tick();
    in_valid = 1'b0;
    chk(tag, "snp_rdresp", snp_rdresp, gd);
    chk(tag, "snp_ack", snp_ack, ga);
    if (gd || ga) chk(tag, "snp_line", snp_line, ln);
    if (gd) chk(tag, "snp_data", snp_data, m_dat[ln]);
    m_st[ln] = nx;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0E));
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_dat[i] = '0; end
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset outputs
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "snp_rdresp", snp_rdresp, 0);
    chk("R1", "snp_ack", snp_ack, 0);
    // R1/R2 first read misses; second read hits in Shared
    proc(0, 3, '0, 0, 0);
    proc(0, 3, '0, 0, 0);
    // R5 upgrade from Shared with a stray ack on another line
    proc(1, 3, 16'h1234, 0, 1);
    // R6 atomic hit in Modified
    proc(2, 3, 16'h0011, 0, 0);
    // R8 clean then R3 write on Exclusive, then R8 evict of Modified
    proc(4, 3, '0, 0, 0);
    proc(1, 3, 16'hBEEF, 0, 0);
    proc(5, 3, '0, 0, 0);
    proc(0, 3, '0, 0, 0);
    // R4 atomic miss, acks before data
    proc(2, 5, 16'h0101, 1, 0);
    // R9 snoop read of Modified; R11 read-invalidate of Shared
    snoop(0, 5);
    snoop(4, 5);
    proc(0, 5, '0, 0, 0);
    // R4 write miss with data first; R11 read-invalidate of Modified
    proc(1, 6, 16'hCAFE, 0, 0);
    snoop(4, 6);
    // R10 invalidate of an Invalid line still acknowledged
    snoop(2, 0);
    // R7 claim, then R9 snoop read of Exclusive
    proc(0, 2, '0, 0, 0);
    proc(3, 2, '0, 0, 0);
    snoop(0, 2);
    snoop(2, 2);
    // R12 request while busy is ignored
    begin
      logic [DW-1:0] rv;
      rv = 16'h7777;
      req_valid = 1'b1; req_op = 3'd0; req_line = 3'd7;
      tick();
      chk("R12", "miss message", out_msg, 0);
      req_op = 3'd1; req_line = 3'd4; req_wdata = 16'h4444;
      tick();
      req_valid = 1'b0;
      chk("R12", "no message while busy", out_valid, 0);
      chk("R12", "still busy", busy, 1);
      send(1, 7, rv, "R12");
      tick();
      chk("R12", "done", done, 1);
      chk("R12", "state", done_state, 1);
      m_st[7] = 1; m_dat[7] = rv;
      proc(0, 4, '0, 0, 0);
    end
    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 7)
        proc(int'($urandom % 6), int'($urandom % NL), DW'($urandom), bit'($urandom % 2), bit'($urandom % 2));
      else
        snoop((r == 7) ? 0 : ((r == 8) ? 2 : 4), int'($urandom % NL));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule